// File: doc/BRIEF.md
# Cursor Blink and Display Skew Unit

This block sits behind a raster timing generator. Each character clock it receives the current memory address, the scan-line (row) address within the character row, the raw display-enable and a once-per-field pulse. It decides whether the text cursor is showing at this position and whether it is in its visible blink phase. It then passes both the display-enable and the cursor through a short character-clock delay line, so that a slower downstream pixel pipeline can be matched.

Software programs the cursor location, the first and last cursor scan lines, a blink code and two independent skew codes through a simple write port. Each skew code adds zero, one or two character delays, or forces its output off. The "off" code makes whole-screen blanking a single register write.

Top module: `cursor_skew_unit`

## Requirements
- R1: `cursor_out` (with cursor skew 00, blink 00 and `disp_raw`=1) is high exactly when `ma` equals the 14-bit cursor position and `ra` lies between the first and last cursor lines, both ends included.
- R2: The cursor is gated by `disp_raw` before the delay line; with `disp_raw`=0 no cursor is produced.
- R3: Blink code 00 gives a steady cursor; blink code 01 suppresses the cursor entirely.
- R4: Blink code 10 shows the cursor while bit 3 of a 5-bit field counter is 0. The counter clears on reset and advances once per cycle with `field_pulse` high, giving a 16-field period.
- R5: Blink code 11 shows the cursor while bit 4 of the same field counter is 0 (32-field period).
- R6: Display skew code 00 passes `disp_raw` straight to `disp_out`. Code 01 delays it by one character-clock step and code 10 by two.
- R7: Display skew code 11 holds `disp_out` low regardless of `disp_raw`.
- R8: The cursor skew code uses the same encoding (00/01/10 = 0/1/2 steps, 11 = off) and acts on `cursor_out`.
- R9: The delay lines advance only on cycles with `char_en` high; otherwise the outputs hold.
- R10: The register map on `wr_addr` is as follows. Address 8 holds display skew in [5:4] and cursor skew in [7:6]. Address 10 holds the first cursor line in [4:0] and the blink code in [6:5]. Address 11 holds the last cursor line in [4:0]. Address 14 holds cursor position bits 13:8 in [5:0], and address 15 holds position bits 7:0. Writes to any other address change nothing.
- R11: Writing 0xF0 to address 8 blanks `disp_out` from the cycle after the write. Writing 0xC0 restores undelayed display with the cursor forced off.
- R12: Reset clears all registers, the field counter and both delay lines, so the outputs are low while `disp_raw` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| char_en | input | 1 | Character clock enable |
| ma | input | 14 | Current memory address |
| ra | input | 5 | Current scan line within the character row |
| disp_raw | input | 1 | Undelayed display enable from timing |
| field_pulse | input | 1 | One-cycle pulse per field |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 5 | Register address |
| wr_data | input | 8 | Register write data |
| disp_out | output | 1 | Skewed display enable |
| cursor_out | output | 1 | Skewed cursor signal |

## Verification
The slow blink phase is the hardest state to reach from the ports. It appears only after sixteen field pulses and returns only after thirty-two, so the bench issues bursts of back-to-back field pulses and samples the cursor at counts 0, 8, 16 and 32. The skew taps are checked by toggling `disp_raw` or the cursor match condition and watching which clock edge the output follows, with `char_en` both high and held low.

// File: rtl/cursor_skew_pkg.sv
package cursor_skew_pkg;
    localparam int MA_W    = 14;
    localparam int RA_W    = 5;
    localparam int FIELD_W = 5;
    localparam int ADDR_W  = 5;
    localparam int DATA_W  = 8;
    localparam int POS_HI_W = MA_W - DATA_W;

    localparam logic [ADDR_W-1:0] A_SKEW    = 5'd8;
    localparam logic [ADDR_W-1:0] A_CSTART  = 5'd10;
    localparam logic [ADDR_W-1:0] A_CEND    = 5'd11;
    localparam logic [ADDR_W-1:0] A_POS_HI  = 5'd14;
    localparam logic [ADDR_W-1:0] A_POS_LO  = 5'd15;

    typedef enum logic [1:0] {
        SKEW_NONE = 2'b00,
        SKEW_ONE  = 2'b01,
        SKEW_TWO  = 2'b10,
        SKEW_KILL = 2'b11
    } skew_e;

    typedef enum logic [1:0] {
        BLINK_STEADY = 2'b00,
        BLINK_HIDE   = 2'b01,
        BLINK_FAST   = 2'b10,
        BLINK_SLOW   = 2'b11
    } blink_e;

    typedef struct packed {
        skew_e            disp_skew;
        skew_e            cur_skew;
        blink_e           blink;
        logic [RA_W-1:0]  line_first;
        logic [RA_W-1:0]  line_last;
        logic [MA_W-1:0]  pos;
    } cfg_t;
endpackage

// File: rtl/cursor_cfg_regs.sv
module cursor_cfg_regs
    import cursor_skew_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output cfg_t              cfg
);
    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (wr_en) begin
            unique case (wr_addr)
                A_SKEW: begin
                    cfg_d.disp_skew = skew_e'(wr_data[5:4]);
                    cfg_d.cur_skew  = skew_e'(wr_data[7:6]);
                end
                A_CSTART: begin
                    cfg_d.line_first = wr_data[RA_W-1:0];
                    cfg_d.blink      = blink_e'(wr_data[6:5]);
                end
                A_CEND:   cfg_d.line_last = wr_data[RA_W-1:0];
                A_POS_HI: cfg_d.pos[MA_W-1:DATA_W] = wr_data[POS_HI_W-1:0];
                A_POS_LO: cfg_d.pos[DATA_W-1:0] = wr_data;
                default:  cfg_d = cfg_q;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) cfg_q <= '0;
        else        cfg_q <= cfg_d;
    end

    assign cfg = cfg_q;
endmodule

// File: rtl/cursor_match.sv
module cursor_match
    import cursor_skew_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            field_pulse,
    input  logic [MA_W-1:0] ma,
    input  logic [RA_W-1:0] ra,
    input  logic            disp_raw,
    input  cfg_t            cfg,
    output logic            cur_raw
);
    typedef struct packed {
        logic [FIELD_W-1:0] fields;
    } st_t;

    st_t st_d, st_q;
    logic visible;
    logic hit;

    always_comb begin
        st_d = st_q;
        if (field_pulse) st_d.fields = st_q.fields + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (cfg.blink)
            BLINK_STEADY: visible = 1'b1;
            BLINK_HIDE:   visible = 1'b0;
            BLINK_FAST:   visible = ~st_q.fields[3];
            BLINK_SLOW:   visible = ~st_q.fields[4];
            default:      visible = 1'b0;
        endcase
        hit = (ma == cfg.pos) && (ra >= cfg.line_first) && (ra <= cfg.line_last);
        cur_raw = hit && visible && disp_raw;
    end
endmodule

// File: rtl/skew_line.sv
module skew_line
    import cursor_skew_pkg::*;
#(
    parameter int STAGES = 2
) (
    input  logic  clk,
    input  logic  rst_n,
    input  logic  step,
    input  logic  din,
    input  skew_e code,
    output logic  dout
);
    typedef struct packed {
        logic [STAGES-1:0] taps;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (step) begin
            st_d.taps[0] = din;
            for (int i = 1; i < STAGES; i++) st_d.taps[i] = st_q.taps[i-1];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_comb begin
        unique case (code)
            SKEW_NONE: dout = din;
            SKEW_ONE:  dout = st_q.taps[0];
            SKEW_TWO:  dout = st_q.taps[STAGES-1];
            default:   dout = 1'b0;
        endcase
    end
endmodule

// File: rtl/cursor_skew_unit.sv
module cursor_skew_unit
    import cursor_skew_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              char_en,
    input  logic [MA_W-1:0]   ma,
    input  logic [RA_W-1:0]   ra,
    input  logic              disp_raw,
    input  logic              field_pulse,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              disp_out,
    output logic              cursor_out
);
    localparam int N_LINES = 2;

    cfg_t cfg;
    logic cur_raw;
    logic [N_LINES-1:0] line_in, line_out;
    skew_e line_code [N_LINES];

    cursor_cfg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en),
        .wr_addr(wr_addr), .wr_data(wr_data), .cfg(cfg)
    );

    cursor_match u_match (
        .clk(clk), .rst_n(rst_n), .field_pulse(field_pulse),
        .ma(ma), .ra(ra), .disp_raw(disp_raw), .cfg(cfg), .cur_raw(cur_raw)
    );

    assign line_in      = {cur_raw, disp_raw};
    assign line_code[0] = cfg.disp_skew;
    assign line_code[1] = cfg.cur_skew;

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        skew_line #(.STAGES(2)) u_line (
            .clk(clk), .rst_n(rst_n), .step(char_en),
            .din(line_in[g]), .code(line_code[g]), .dout(line_out[g])
        );
    end

    assign disp_out   = line_out[0];
    assign cursor_out = line_out[1];
endmodule

// File: rtl/cursor_skew_chk.sv
module cursor_skew_chk
    import cursor_skew_pkg::*;
(
    input logic            clk,
    input logic            rst_n,
    input logic            char_en,
    input logic            wr_en,
    input logic            disp_raw,
    input logic [MA_W-1:0] ma,
    input logic            disp_out,
    input logic            cursor_out,
    input cfg_t            cfg
);
    // R7
    disp_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.disp_skew == SKEW_KILL) |-> !disp_out);

    // R8
    cur_kill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.cur_skew == SKEW_KILL) |-> !cursor_out);

    // R6
    disp_pass_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.disp_skew == SKEW_NONE) |-> (disp_out == disp_raw));

    // R6
    disp_one_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.disp_skew == SKEW_ONE && char_en && !wr_en) |=> (disp_out == $past(disp_raw)));

    // R2
    cur_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.cur_skew == SKEW_NONE && cursor_out) |-> (disp_raw && ma == cfg.pos));

    // R3
    cur_hide_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.cur_skew == SKEW_NONE && cfg.blink == BLINK_HIDE) |-> !cursor_out);

    // R9
    hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!char_en && !wr_en && cfg.disp_skew == SKEW_TWO) |=> $stable(disp_out));
endmodule

bind cursor_skew_unit cursor_skew_chk u_chk (
    .clk(clk), .rst_n(rst_n), .char_en(char_en), .wr_en(wr_en),
    .disp_raw(disp_raw), .ma(ma), .disp_out(disp_out),
    .cursor_out(cursor_out), .cfg(cfg)
);

// File: tb/cursor_skew_unit_test.sv
module cursor_skew_unit_test;
    logic        clk = 0;
    logic        rst_n = 0;
    logic        char_en = 1;
    logic [13:0] ma = '0;
    logic [4:0]  ra = '0;
    logic        disp_raw = 0;
    logic        field_pulse = 0;
    logic        wr_en = 0;
    logic [4:0]  wr_addr = '0;
    logic [7:0]  wr_data = '0;
    logic        disp_out, cursor_out;

    int checks = 0;
    int errors = 0;

    always #5 clk = ~clk;

    cursor_skew_unit uut (.*);

    typedef struct packed {
        logic [13:0] ma;
        logic [4:0]  ra;
        logic        disp;
        logic [1:0]  blink;
        logic        exp_cur;
    } vec_t;

    localparam int NV = 10;
    localparam vec_t VECS [NV] = '{
        '{14'h1234, 5'd3, 1'b1, 2'd0, 1'b1},  // R1 first line
        '{14'h1234, 5'd6, 1'b1, 2'd0, 1'b1},  // R1 last line
        '{14'h1234, 5'd2, 1'b1, 2'd0, 1'b0},  // R1 above
        '{14'h1234, 5'd7, 1'b1, 2'd0, 1'b0},  // R1 below
        '{14'h1235, 5'd4, 1'b1, 2'd0, 1'b0},  // R1 address off by one
        '{14'h0234, 5'd4, 1'b1, 2'd0, 1'b0},  // R1 high bits differ
        '{14'h1234, 5'd4, 1'b0, 2'd0, 1'b0},  // R2 border
        '{14'h1234, 5'd4, 1'b1, 2'd1, 1'b0},  // R3 hidden
        '{14'h1234, 5'd5, 1'b1, 2'd2, 1'b1},  // R4 field 0
        '{14'h1234, 5'd5, 1'b1, 2'd3, 1'b1}   // R5 field 0
    };

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_en = 1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 0;
    endtask

    task automatic fields(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            field_pulse = 1;
            @(negedge clk);
            field_pulse = 0;
        end
    endtask

    initial begin
        #1000000;
        errors++; checks++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        // R12 reset state
        check("R12 disp", disp_out, 1'b0);
        check("R12 cursor", cursor_out, 1'b0);
        rst_n = 1;
        @(negedge clk);
        ma = 14'h0000; ra = 5'd0; disp_raw = 1; #1;
        // R12: cleared position 0, lines 0..0, steady, no skew
        check("R12 cleared regs cursor", cursor_out, 1'b1);

        // R10 program position 0x1234, lines 3..6
        wr(5'd14, 8'h12);
        wr(5'd15, 8'h34);
        wr(5'd11, 8'd6);
        for (int i = 0; i < NV; i++) begin
            wr(5'd10, {1'b0, VECS[i].blink, 5'd3});
            ma = VECS[i].ma; ra = VECS[i].ra; disp_raw = VECS[i].disp; #1;
            check($sformatf("R1/R2/R3 vec%0d cursor", i), cursor_out, VECS[i].exp_cur);
            check($sformatf("R6 vec%0d disp", i), disp_out, VECS[i].disp);
        end

        // R10 ignored addresses
        wr(5'd10, 8'h03);
        wr(5'd12, 8'hFF);
        wr(5'd13, 8'hFF);
        wr(5'd9, 8'h1F);
        ma = 14'h1234; ra = 5'd4; disp_raw = 1; #1;
        check("R10 ignored writes keep cursor", cursor_out, 1'b1);
        ma = 14'h3FFF; #1;
        check("R10 ignored writes no new position", cursor_out, 1'b0);
        ma = 14'h1234;

        // R4 fast blink
        wr(5'd10, 8'h43);
        fields(8); #1;
        check("R4 field 8 hidden", cursor_out, 1'b0);
        fields(8); #1;
        check("R4 field 16 shown", cursor_out, 1'b1);
        // R5 slow blink at field 16
        wr(5'd10, 8'h63); #1;
        check("R5 field 16 hidden", cursor_out, 1'b0);
        fields(8); #1;
        check("R5 field 24 hidden", cursor_out, 1'b0);
        fields(8); #1;
        check("R5 field 32 shown", cursor_out, 1'b1);
        wr(5'd10, 8'h03);

        // R6 one-step delay
        wr(5'd8, 8'h10);
        disp_raw = 0; @(negedge clk); @(negedge clk);
        disp_raw = 1; #1;
        check("R6 skew1 before edge", disp_out, 1'b0);
        @(negedge clk); #1;
        check("R6 skew1 after edge", disp_out, 1'b1);
        // R9 hold when char_en low
        char_en = 0; disp_raw = 0;
        @(negedge clk); @(negedge clk); #1;
        check("R9 hold skew1", disp_out, 1'b1);
        char_en = 1;
        @(negedge clk); #1;
        check("R9 resume skew1", disp_out, 1'b0);

        // R6 two-step delay
        wr(5'd8, 8'h20);
        @(negedge clk); @(negedge clk);
        disp_raw = 1; #1;
        check("R6 skew2 t0", disp_out, 1'b0);
        @(negedge clk); #1;
        check("R6 skew2 t1", disp_out, 1'b0);
        @(negedge clk); #1;
        check("R6 skew2 t2", disp_out, 1'b1);

        // R8 cursor delay one step
        wr(5'd8, 8'h40);
        ma = 14'h0001; @(negedge clk); @(negedge clk);
        ma = 14'h1234; #1;
        check("R8 cursor skew1 before", cursor_out, 1'b0);
        @(negedge clk); #1;
        check("R8 cursor skew1 after", cursor_out, 1'b1);
        // R8 cursor two steps
        wr(5'd8, 8'h80);
        ma = 14'h0001; @(negedge clk); @(negedge clk);
        ma = 14'h1234; #1;
        check("R8 cursor skew2 t0", cursor_out, 1'b0);
        @(negedge clk); #1;
        check("R8 cursor skew2 t1", cursor_out, 1'b0);
        @(negedge clk); #1;
        check("R8 cursor skew2 t2", cursor_out, 1'b1);

        // R11 blank with 0xF0 (R7, R8 kill)
        wr(5'd8, 8'hF0); #1;
        check("R11 R7 blank", disp_out, 1'b0);
        check("R11 R8 cursor off", cursor_out, 1'b0);
        // R11 restore with 0xC0
        wr(5'd8, 8'hC0); #1;
        check("R11 restore disp", disp_out, 1'b1);
        check("R11 cursor still off", cursor_out, 1'b0);
        disp_raw = 0; #1;
        check("R11 undelayed follow", disp_out, 1'b0);

        // R12 reset clears delay line and counter
        wr(5'd8, 8'h20);
        disp_raw = 1; @(negedge clk); @(negedge clk);
        rst_n = 0; disp_raw = 0;
        @(negedge clk); rst_n = 1; #1;
        check("R12 after reset disp", disp_out, 1'b0);
        check("R12 after reset cursor", cursor_out, 1'b0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule